// File: doc/BRIEF.md
# Printer Port Register Block

This block gives a host bus byte-wide access to a standard printer port. The bus offers one access per cycle: an enable, a write flag, a three-bit register offset, a single-byte qualifier and write data. Read data returns one cycle later with a valid strobe. Behind the bus sit five registers: a data latch, a status view of the printer lines, a control register and two plain holding bytes for enhanced-mode address and data.

The data latch drives the printer data pins. Setting the bidirectional bit in the control register turns the pins around: the output driver is released, and a data read samples the pins and keeps the sampled byte. Status and data inputs pass through a synchronizer before any logic uses them. A falling edge on the synchronized acknowledge line raises a level interrupt, but only while the acknowledge-interrupt enable bit is set. The interrupt stays up until the status register is read.

Top module: `pport_if`

## Requirements
- R1: The offset selects data (0), status (1), control (2), enhanced address (3) and enhanced data (4). Offsets 5 to 7 hold no register.
- R2: A single-byte write to offset 0 loads the data latch, which appears on `pd_out` one cycle later. While control bit 5 is clear, `pd_oe` is 1 and a data read returns the latch.
- R3: While control bit 5 (bidirectional) is set, `pd_oe` is 0. A data read returns the synchronized `pd_in` and also stores it in the data latch, so `pd_out` shows it once bit 5 is cleared.
- R4: A control write stores the written byte with bits 7 and 6 forced to 1. `ctl_out` shows the register. Bit 4 enables the acknowledge interrupt, and bits 3..0 are select, init, auto-feed and strobe.
- R5: `ctl_chg` pulses for one cycle after a control write only when the forced value differs from the current register. Otherwise the register and `ctl_out` are unchanged.
- R6: A status read returns {busy, ack, paper-out, select, error, pending-interrupt, 1, 0} from bit 7 down to bit 0. The five line bits are `st_in[4:0]` after SYNC_STAGES clock stages.
- R7: A falling edge of synchronized ack (`st_in[3]`) sets `irq` on the next cycle, if control bit 4 was set in that cycle. `irq` then holds.
- R8: A status read clears `irq` on the next cycle. An acknowledge edge in the same cycle wins, and `irq` stays set.
- R9: Offsets 3 and 4 are plain read/write byte latches.
- R10: Writes to offsets 1, 5, 6 and 7 change no output. Reads of offsets 5 to 7 return 8'hFF.
- R11: An access with `acc_single` low is rejected. A write changes nothing, and a read returns 8'hFF without side effects.
- R12: Reset clears the data latch, the enhanced latches and the interrupt. It loads control with 8'hC0 and drops `acc_rvalid`.
- R13: `acc_rvalid` pulses in the cycle after each read request, with `acc_rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ofs | input | 3 | Register offset |
| acc_single | input | 1 | Access is exactly one byte |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data valid, one cycle after the request |
| pd_in | input | 8 | Printer data pins, input side |
| pd_out | output | 8 | Printer data pins, output side |
| pd_oe | output | 1 | Data pin output enable |
| st_in | input | 5 | Busy, ack, paper-out, select, error lines (bit 4 to 0) |
| ctl_out | output | 8 | Control register driven to the printer lines |
| ctl_chg | output | 1 | One-cycle pulse when control changed |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This stretches the delay from a pin change to its visibility in status reads, bidirectional data reads and acknowledge detection. A model that miscounted the synchronizer would fail at once. Acknowledge falls are placed from zero to several cycles before a status read, so the clear-versus-set collision of R8 is reached at one of those offsets.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int BYTE_W     = 8;
    localparam int LINE_W     = 5;
    localparam int CB_BIDIR   = 5;
    localparam int CB_ACKIE   = 4;
    localparam int SL_ACK     = 3;
    localparam logic [BYTE_W-1:0] CTL_FIXED = 8'hC0;
    localparam logic [BYTE_W-1:0] NO_REG    = 8'hFF;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_STAT = 3'd1,
        OFS_CTRL = 3'd2,
        OFS_EADR = 3'd3,
        OFS_EDAT = 3'd4,
        OFS_NR5  = 3'd5,
        OFS_NR6  = 3'd6,
        OFS_NR7  = 3'd7
    } ofs_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              ok;
        ofs_e              ofs;
        logic [BYTE_W-1:0] wdata;
    } req_t;

    function automatic logic [BYTE_W-1:0] ctl_force(input logic [BYTE_W-1:0] v);
        return v | CTL_FIXED;
    endfunction

    function automatic logic [BYTE_W-1:0] stat_pack(input logic [LINE_W-1:0] lines,
                                                    input logic pend);
        return {lines, pend, 1'b1, 1'b0};
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stg
            logic [W-1:0] r;
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) r <= '0;
                    else     r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) r <= '0;
                    else     r <= g_stg[s-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stg[LAST].r;
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
    input  logic clk,
    input  logic rst,
    input  logic ack_s,
    input  logic enable,
    input  logic clear,
    output logic pend
);
    logic ack_prev;
    logic ack_fall;

    assign ack_fall = ack_prev & ~ack_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_prev <= 1'b0;
            pend     <= 1'b0;
        end else begin
            ack_prev <= ack_s;
            if (ack_fall && enable) pend <= 1'b1;
            else if (clear)         pend <= 1'b0;
        end
    end
endmodule

// File: rtl/pport_core.sv
module pport_core
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  logic [BYTE_W-1:0] pd_s,
    input  logic [LINE_W-1:0] st_s,
    input  logic              irq_pend,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] ctl_q,
    output logic              ctl_chg,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid,
    output logic              stat_rd
);
    logic [BYTE_W-1:0] eadr_q;
    logic [BYTE_W-1:0] edat_q;
    logic [BYTE_W-1:0] ctl_next;
    logic [BYTE_W-1:0] rd_mux;
    logic              bidir;
    logic              rd_ok;
    logic              ctl_diff;
    logic              data_cap;

    assign bidir    = ctl_q[CB_BIDIR];
    assign rd_ok    = req.rd & req.ok;
    assign ctl_next = ctl_force(req.wdata);
    assign ctl_diff = req.wr && (req.ofs == OFS_CTRL) && (ctl_next != ctl_q);
    assign data_cap = rd_ok && (req.ofs == OFS_DATA) && bidir;
    assign stat_rd  = rd_ok && (req.ofs == OFS_STAT);

    always_comb begin
        rd_mux = NO_REG;
        if (req.ok) begin
            unique case (req.ofs)
                OFS_DATA: rd_mux = bidir ? pd_s : data_q;
                OFS_STAT: rd_mux = stat_pack(st_s, irq_pend);
                OFS_CTRL: rd_mux = ctl_q;
                OFS_EADR: rd_mux = eadr_q;
                OFS_EDAT: rd_mux = edat_q;
                default:  rd_mux = NO_REG;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ctl_q   <= CTL_FIXED;
            eadr_q  <= '0;
            edat_q  <= '0;
            ctl_chg <= 1'b0;
            rdata   <= '0;
            rvalid  <= 1'b0;
        end else begin
            ctl_chg <= ctl_diff;
            rvalid  <= req.rd;
            if (req.rd) rdata <= rd_mux;
            if (data_cap) data_q <= pd_s;
            if (ctl_diff) ctl_q  <= ctl_next;
            if (req.wr) begin
                unique case (req.ofs)
                    OFS_DATA: data_q <= req.wdata;
                    OFS_EADR: eadr_q <= req.wdata;
                    OFS_EDAT: edat_q <= req.wdata;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pport_if.sv
module pport_if
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [2:0]  acc_ofs,
    input  logic        acc_single,
    input  logic [7:0]  acc_wdata,
    output logic [7:0]  acc_rdata,
    output logic        acc_rvalid,
    input  logic [7:0]  pd_in,
    output logic [7:0]  pd_out,
    output logic        pd_oe,
    input  logic [4:0]  st_in,
    output logic [7:0]  ctl_out,
    output logic        ctl_chg,
    output logic        irq
);
    req_t              req;
    logic [BYTE_W-1:0] pd_s;
    logic [LINE_W-1:0] st_s;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] ctl_q;
    logic              stat_rd;
    logic              pend;

    always_comb begin
        req.rd    = acc_en & ~acc_wr;
        req.wr    = acc_en & acc_wr & acc_single;
        req.ok    = acc_single;
        req.ofs   = ofs_e'(acc_ofs);
        req.wdata = acc_wdata;
    end

    pport_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES)) u_pd_sync (
        .clk(clk), .rst(rst), .d(pd_in), .q(pd_s)
    );

    pport_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_st_sync (
        .clk(clk), .rst(rst), .d(st_in), .q(st_s)
    );

    pport_core u_core (
        .clk(clk), .rst(rst), .req(req), .pd_s(pd_s), .st_s(st_s),
        .irq_pend(pend), .data_q(data_q), .ctl_q(ctl_q), .ctl_chg(ctl_chg),
        .rdata(acc_rdata), .rvalid(acc_rvalid), .stat_rd(stat_rd)
    );

    pport_irq u_irq (
        .clk(clk), .rst(rst), .ack_s(st_s[SL_ACK]), .enable(ctl_q[CB_ACKIE]),
        .clear(stat_rd), .pend(pend)
    );

    assign pd_out  = data_q;
    assign pd_oe   = ~ctl_q[CB_BIDIR];
    assign ctl_out = ctl_q;
    assign irq     = pend;
endmodule

// File: rtl/pport_chk.sv
module pport_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_en,
    input logic       acc_wr,
    input logic [2:0] acc_ofs,
    input logic       acc_single,
    input logic [7:0] ctl_out,
    input logic [7:0] pd_out,
    input logic       pd_oe,
    input logic       ctl_chg,
    input logic       acc_rvalid,
    input logic       irq
);
    // R7
    irq_rise_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ctl_out[4]));

    // R8
    irq_fall_needs_status_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(acc_en && !acc_wr && acc_single && acc_ofs == 3'd1));

    // R5
    ctl_chg_means_new_value_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_chg |-> (ctl_out != $past(ctl_out)));

    // R13
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        acc_rvalid |-> $past(acc_en && !acc_wr));

    // R3
    oe_returns_on_ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_oe) |-> $past(acc_en && acc_wr && acc_ofs == 3'd2));

    // R10
    dead_offset_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_wr && acc_ofs >= 3'd5) |=>
            ($stable(ctl_out) && $stable(pd_out) && $stable(pd_oe)));
endmodule

bind pport_if pport_chk u_chk (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_ofs(acc_ofs),
    .acc_single(acc_single), .ctl_out(ctl_out), .pd_out(pd_out), .pd_oe(pd_oe),
    .ctl_chg(ctl_chg), .acc_rvalid(acc_rvalid), .irq(irq)
);

// File: tb/pport_if_bench.sv
module pport_if_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STG        = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_en = 1'b0, acc_wr = 1'b0, acc_single = 1'b1;
    logic [2:0] acc_ofs = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] pd_in = '0;
    logic [4:0] st_in = 5'b01000;
    logic [7:0] acc_rdata, pd_out, ctl_out;
    logic       acc_rvalid, pd_oe, ctl_chg, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_if #(.SYNC_STAGES(STG)) u_pport_if (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_ofs(acc_ofs),
        .acc_single(acc_single), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_rvalid(acc_rvalid), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .st_in(st_in), .ctl_out(ctl_out), .ctl_chg(ctl_chg), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] m_data, m_ctl, m_ea, m_ed, m_rdata;
    logic       m_rvalid, m_irq, m_chg, m_ackp;
    logic [4:0] st_h [STG];
    logic [7:0] pd_h [STG];
    string      m_tag = "R13";

    always @(posedge clk) begin : mdl
        logic [4:0] sts;
        logic [7:0] pds;
        logic [7:0] old_ctl;
        logic       fall, clr, old_irq;
        if (rst) begin
            m_data = 0; m_ctl = 8'hC0; m_ea = 0; m_ed = 0; m_rdata = 0;
            m_rvalid = 0; m_irq = 0; m_chg = 0; m_ackp = 0;
            for (int i = 0; i < STG; i++) begin st_h[i] = 0; pd_h[i] = 0; end
        end else begin
            sts = st_h[STG-1]; pds = pd_h[STG-1];
            fall = m_ackp && !sts[3];
            m_ackp = sts[3];
            for (int i = STG-1; i > 0; i--) begin st_h[i] = st_h[i-1]; pd_h[i] = pd_h[i-1]; end
            st_h[0] = st_in; pd_h[0] = pd_in;
            old_ctl = m_ctl; old_irq = m_irq; clr = 0; m_rvalid = 0; m_chg = 0;
            if (acc_en && !acc_wr) begin
                m_rvalid = 1;
                if (!acc_single) begin m_rdata = 8'hFF; m_tag = "R11"; end
                else case (acc_ofs)
                    3'd0: if (old_ctl[5]) begin m_rdata = pds; m_data = pds; m_tag = "R3"; end
                          else begin m_rdata = m_data; m_tag = "R2"; end
                    3'd1: begin m_rdata = {sts, old_irq, 2'b10}; clr = 1; m_tag = "R6"; end
                    3'd2: begin m_rdata = m_ctl; m_tag = "R4"; end
                    3'd3: begin m_rdata = m_ea; m_tag = "R9"; end
                    3'd4: begin m_rdata = m_ed; m_tag = "R9"; end
                    default: begin m_rdata = 8'hFF; m_tag = "R10"; end
                endcase
            end
            if (acc_en && acc_wr && acc_single) begin
                case (acc_ofs)
                    3'd0: m_data = acc_wdata;
                    3'd2: if ((acc_wdata | 8'hC0) != m_ctl) begin m_ctl = acc_wdata | 8'hC0; m_chg = 1; end
                    3'd3: m_ea = acc_wdata;
                    3'd4: m_ed = acc_wdata;
                    default: ;
                endcase
            end
            if (fall && old_ctl[4]) m_irq = 1;
            else if (clr)           m_irq = 0;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R13 rvalid", {7'd0, acc_rvalid}, {7'd0, m_rvalid});
            if (m_rvalid) chk(m_tag, acc_rdata, m_rdata);
            chk("R2 pd_out", pd_out, m_data);
            chk("R3 pd_oe", {7'd0, pd_oe}, {7'd0, !m_ctl[5]});
            chk("R4 ctl_out", ctl_out, m_ctl);
            chk("R5 ctl_chg", {7'd0, ctl_chg}, {7'd0, m_chg});
            chk("R7 irq", {7'd0, irq}, {7'd0, m_irq});
        end
    end

    task automatic acc(input logic wr, input logic [2:0] ofs, input logic [7:0] d,
                       input logic single = 1'b1);
        acc_en = 1; acc_wr = wr; acc_ofs = ofs; acc_wdata = d; acc_single = single;
        @(negedge clk);
        acc_en = 0; acc_wr = 0; acc_single = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        chk("R12 ctl", ctl_out, 8'hC0);
        chk("R12 data", pd_out, 8'h00);
        chk("R12 irq", {7'd0, irq}, 8'h00);
        chk("R12 rvalid", {7'd0, acc_rvalid}, 8'h00);
        acc(0, 3'd3, 0); chk("R12 eadr", acc_rdata, 8'h00);
        // R1 R2 data latch
        acc(1, 3'd0, 8'h5A); chk("R2 out", pd_out, 8'h5A);
        acc(0, 3'd0, 0);     chk("R1 data ofs", acc_rdata, 8'h5A);
        // R4 R5 control
        acc(1, 3'd2, 8'h00); chk("R5 same value", {7'd0, ctl_chg}, 8'h00);
        acc(1, 3'd2, 8'h0F); chk("R5 pulse", {7'd0, ctl_chg}, 8'h01);
        chk("R4 forced", ctl_out, 8'hCF);
        acc(1, 3'd2, 8'h0F); chk("R5 repeat", {7'd0, ctl_chg}, 8'h00);
        acc(0, 3'd2, 0);     chk("R1 ctl ofs", acc_rdata, 8'hCF);
        // R9 latches
        acc(1, 3'd3, 8'h12); acc(1, 3'd4, 8'h34);
        acc(0, 3'd3, 0);     chk("R9 eadr", acc_rdata, 8'h12);
        acc(0, 3'd4, 0);     chk("R9 edat", acc_rdata, 8'h34);
        // R10 dead offsets
        for (int o = 5; o < 8; o++) begin
            acc(1, 3'(o), 8'h20);
            chk("R10 ctl kept", ctl_out, 8'hCF);
            acc(0, 3'(o), 0);
            chk("R10 read", acc_rdata, 8'hFF);
        end
        acc(1, 3'd1, 8'h00);
        // R11 non-single
        acc(1, 3'd0, 8'hEE, 1'b0); chk("R11 write", pd_out, 8'h5A);
        acc(0, 3'd2, 0, 1'b0);     chk("R11 read", acc_rdata, 8'hFF);
        // R3 bidirectional
        pd_in = 8'hC3;
        acc(1, 3'd2, 8'h20); chk("R3 oe off", {7'd0, pd_oe}, 8'h00);
        idle(STG + 1);
        acc(0, 3'd0, 0);     chk("R3 pins", acc_rdata, 8'hC3);
        pd_in = 8'h3C;
        acc(1, 3'd2, 8'h00); chk("R3 stored", pd_out, 8'hC3);
        // R6 status lines
        for (int p = 0; p < 4; p++) begin
            st_in = 5'(p * 9 + 3);
            idle(STG + 1);
            acc(0, 3'd1, 0);
        end
        // R7 ack with interrupt disabled
        st_in = 5'b01000; idle(STG + 2);
        st_in = 5'b00000; idle(STG + 2);
        chk("R7 disabled", {7'd0, irq}, 8'h00);
        // R7 R8 enabled, sweep ack-to-read spacing
        acc(1, 3'd2, 8'h10);
        for (int d = 0; d < 6; d++) begin
            st_in = 5'b01000; idle(STG + 2);
            st_in = 5'b00000;
            idle(d);
            acc(0, 3'd1, 0);
            idle(STG + 2);
            acc(0, 3'd1, 0);
            chk("R8 cleared", {7'd0, irq}, 8'h00);
        end
        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule